// File: doc/BRIEF.md
# Pipelined DES Block Cipher Core

This block is a DES cipher in electronic codebook form with all sixteen rounds laid out in hardware. On any clock it can accept one 64-bit block together with its own 64-bit key and a direction flag, and it returns the transformed block after a fixed delay. The block first passes through the initial bit permutation and then through sixteen Feistel rounds. The swapped pair of halves then passes through the inverse permutation. Each round is cut into three register stages: subkey selection with expansion, S-box substitution with permutation, and the half swap. The core therefore never stalls and delivers one result per clock.

Each block carries its key and its direction down the pipeline. Adjacent blocks may use unrelated keys and opposite directions. A round takes its subkey from the carried key, which is reduced to 56 bits once at entry. It applies one of two fixed rotations chosen by the carried direction, then the compression selection. Decryption uses the same datapath and visits the subkeys in reverse order.

Top module: `des_ecb_pipe`

## Requirements
- R1: With `in_decrypt` = 0 the result is the DES encryption of `in_block` under `in_key`, both taken MSB-first as DES bit 1. For example, key 0 with block 0x8000000000000000 gives 0x95F8A5E5DD31D900, and key 0x133457799BBCDFF1 with block 0x0123456789ABCDEF gives 0x85E813540F0AB405.
- R2: With `in_decrypt` = 1 the result is the DES decryption, so 0x95F8A5E5DD31D900 under key 0 returns 0x8000000000000000.
- R3: The first rising edge is the one that samples `in_valid` high. The result and `out_valid` are presented after the 48th rising edge, counting from that first one.
- R4: A block is accepted on every clock with no stall, and results leave in the order the blocks entered.
- R5: The direction flag belongs to its own block, so encrypt and decrypt blocks may alternate clock by clock.
- R6: The key belongs to its own block, so a different key on each clock gives each block the result for its own key.
- R7: The least significant bit of every key byte has no effect on the result.
- R8: An active-high synchronous `rst` holds `out_valid` low and discards every block in flight. After release, new blocks are processed normally.
- R9: A clock with `in_valid` low yields no result, whatever the data, key and flag inputs hold in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Block, key and flag are presented this cycle |
| in_decrypt | input | 1 | 0 = encrypt, 1 = decrypt |
| in_key | input | 64 | Key, byte LSBs ignored |
| in_block | input | 64 | Plaintext or ciphertext block |
| out_valid | output | 1 | `out_block` holds a result |
| out_block | output | 64 | Transformed block |

## Verification
The hardest coincidence is one round holding an encrypting block in one stage and a decrypting block under a different key in the next stage. When that happens the round's subkey rotation must follow each block's carried flag and key, not a shared setting. The bench provokes this by feeding a back-to-back stream that flips direction and key on every clock, including decryptions of ciphertexts produced earlier in the same stream. A scoreboard judges the stream by matching every emerging result, in order, against known answers and by checking that each result appears exactly 48 cycles after its block entered.

// File: rtl/des_pkg.sv
package des_pkg;
   localparam int BLK_W       = 64;
   localparam int HALF_W      = BLK_W / 2;
   localparam int CD_W        = 56;
   localparam int HCD_W       = CD_W / 2;
   localparam int SUB_W       = 48;
   localparam int SB_N        = 8;
   localparam int ROUND_N     = 16;
   localparam int STG_PER_RND = 3;
   localparam int LATENCY     = ROUND_N * STG_PER_RND;

   // permutation of the 32-bit S-box output (entry 0 listed first)
   localparam logic [31:0][5:0] P_TBL = {
      6'd16, 6'd7,  6'd20, 6'd21, 6'd29, 6'd12, 6'd28, 6'd17,
      6'd1,  6'd15, 6'd23, 6'd26, 6'd5,  6'd18, 6'd31, 6'd10,
      6'd2,  6'd8,  6'd24, 6'd14, 6'd32, 6'd27, 6'd3,  6'd9,
      6'd19, 6'd13, 6'd30, 6'd6,  6'd22, 6'd11, 6'd4,  6'd25};

   // compression selection of 48 subkey bits from 56 (entry 0 listed first)
   localparam logic [47:0][5:0] PC2_TBL = {
      6'd14, 6'd17, 6'd11, 6'd24, 6'd1,  6'd5,  6'd3,  6'd28,
      6'd15, 6'd6,  6'd21, 6'd10, 6'd23, 6'd19, 6'd12, 6'd4,
      6'd26, 6'd8,  6'd16, 6'd7,  6'd27, 6'd20, 6'd13, 6'd2,
      6'd41, 6'd52, 6'd31, 6'd37, 6'd47, 6'd55, 6'd30, 6'd40,
      6'd51, 6'd45, 6'd33, 6'd48, 6'd44, 6'd49, 6'd39, 6'd56,
      6'd34, 6'd53, 6'd46, 6'd42, 6'd50, 6'd36, 6'd29, 6'd32};

   // source bit (1 = MSB) feeding output position i of the initial permutation
   function automatic int ip_src(int i);
      int row;
      int col;
      row = i / 8;
      col = i % 8;
      return ((row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4))) - 8 * col;
   endfunction

   function automatic logic [63:0] ip_fwd(logic [63:0] x);
      logic [63:0] y;
      for (int i = 0; i < 64; i++) y[63-i] = x[64-ip_src(i)];
      return y;
   endfunction

   function automatic logic [63:0] ip_inv(logic [63:0] x);
      logic [63:0] y;
      for (int i = 0; i < 64; i++) y[64-ip_src(i)] = x[63-i];
      return y;
   endfunction

   function automatic logic [47:0] e_expand(logic [31:0] r);
      logic [47:0] y;
      int src;
      for (int i = 0; i < 48; i++) begin
         src = ((4 * (i / 6) + (i % 6) + 31) % 32) + 1;
         y[47-i] = r[32-src];
      end
      return y;
   endfunction

   function automatic logic [31:0] p_perm(logic [31:0] s);
      logic [31:0] y;
      for (int i = 0; i < 32; i++) y[31-i] = s[32-int'(P_TBL[31-i])];
      return y;
   endfunction

   function automatic int pc1_src(int j);
      int k;
      if (j < 28) return 57 + (j / 8) - 8 * (j % 8);
      else if (j < 52) begin
         k = j - 28;
         return 63 - (k / 8) - 8 * (k % 8);
      end
      return 28 - 8 * (j - 52);
   endfunction

   function automatic logic [55:0] pc1(logic [63:0] key);
      logic [55:0] y;
      for (int j = 0; j < 56; j++) y[55-j] = key[64-pc1_src(j)];
      return y;
   endfunction

   function automatic logic [47:0] pc2(logic [55:0] cd);
      logic [47:0] y;
      for (int i = 0; i < 48; i++) y[47-i] = cd[56-int'(PC2_TBL[47-i])];
      return y;
   endfunction

   function automatic logic [27:0] rotl28(logic [27:0] x, int n);
      logic [55:0] d;
      d = {x, x};
      return d[55-n -: 28];
   endfunction

   function automatic logic [55:0] rot_cd(logic [55:0] cd, int n);
      return {rotl28(cd[55:28], n), rotl28(cd[27:0], n)};
   endfunction

   // total left rotation of both key halves after round r (0-based)
   function automatic int cum_shift(int r);
      case (r)
         0: return 1;    1: return 2;    2: return 4;    3: return 6;
         4: return 8;    5: return 10;   6: return 12;   7: return 14;
         8: return 15;   9: return 17;   10: return 19;  11: return 21;
         12: return 23;  13: return 25;  14: return 27;  default: return 28;
      endcase
   endfunction

   function automatic logic [3:0] sbox_val(int n, logic [5:0] a);
      logic [255:0] t;
      logic [5:0]   idx;
      case (n)
         0: t = 256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D;
         1: t = 256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9;
         2: t = 256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C;
         3: t = 256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E;
         4: t = 256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453;
         5: t = 256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D;
         6: t = 256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C;
         default: t = 256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B;
      endcase
      idx = {a[5], a[0], a[4:1]};
      return t[255 - 4 * int'(idx) -: 4];
   endfunction
endpackage

// File: rtl/des_subkey.sv
module des_subkey
   import des_pkg::*;
#(
   parameter int RND = 0
) (
   input  logic [CD_W-1:0]  cd_i,
   input  logic             dec_i,
   output logic [SUB_W-1:0] sk_o
);
   localparam int ENC_ROT = cum_shift(RND);
   localparam int DEC_ROT = cum_shift(ROUND_N - 1 - RND);

   if (RND < 0 || RND >= ROUND_N) begin : g_bad_rnd
      $error("des_subkey: round index out of range");
   end

   always_comb begin
      sk_o = dec_i ? pc2(rot_cd(cd_i, DEC_ROT)) : pc2(rot_cd(cd_i, ENC_ROT));
   end
endmodule

// File: rtl/des_sbox_layer.sv
module des_sbox_layer
   import des_pkg::*;
(
   input  logic [SUB_W-1:0]  x_i,
   output logic [HALF_W-1:0] f_o
);
   localparam int SB_IN  = SUB_W / SB_N;
   localparam int SB_OUT = HALF_W / SB_N;

   if (SB_IN != 6 || SB_OUT != 4) begin : g_bad_geom
      $error("des_sbox_layer: S-box geometry must be 6 to 4");
   end

   logic [HALF_W-1:0] s_cat;

   for (genvar g = 0; g < SB_N; g++) begin : g_sb
      assign s_cat[HALF_W-1-SB_OUT*g -: SB_OUT] = sbox_val(g, x_i[SUB_W-1-SB_IN*g -: SB_IN]);
   end

   assign f_o = p_perm(s_cat);
endmodule

// File: rtl/des_round.sv
module des_round
   import des_pkg::*;
#(
   parameter int RND = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              v_i,
   input  logic              dec_i,
   input  logic [CD_W-1:0]   key_i,
   input  logic [HALF_W-1:0] l_i,
   input  logic [HALF_W-1:0] r_i,
   output logic              v_o,
   output logic              dec_o,
   output logic [CD_W-1:0]   key_o,
   output logic [HALF_W-1:0] l_o,
   output logic [HALF_W-1:0] r_o
);
   logic [SUB_W-1:0]  sk;
   logic [HALF_W-1:0] f_comb;

   // stage A: subkey mixed into the expanded right half
   logic              va, deca;
   logic [CD_W-1:0]   keya;
   logic [HALF_W-1:0] la, ra;
   logic [SUB_W-1:0]  xa;
   // stage B: substitution and permutation
   logic              vb, decb;
   logic [CD_W-1:0]   keyb;
   logic [HALF_W-1:0] lb, rb, fb;

   des_subkey #(.RND(RND)) u_subkey (
      .cd_i (key_i),
      .dec_i(dec_i),
      .sk_o (sk)
   );

   des_sbox_layer u_sbl (
      .x_i(xa),
      .f_o(f_comb)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         va  <= 1'b0;
         vb  <= 1'b0;
         v_o <= 1'b0;
      end else begin
         va  <= v_i;
         vb  <= va;
         v_o <= vb;
      end
   end

   always_ff @(posedge clk) begin
      deca  <= dec_i;
      keya  <= key_i;
      la    <= l_i;
      ra    <= r_i;
      xa    <= e_expand(r_i) ^ sk;
      decb  <= deca;
      keyb  <= keya;
      lb    <= la;
      rb    <= ra;
      fb    <= f_comb;
      dec_o <= decb;
      key_o <= keyb;
      l_o   <= rb;
      r_o   <= lb ^ fb;
   end

   // R4
   round_adv_chk: assert property (@(posedge clk) disable iff (rst)
      v_i |-> ##3 v_o);
   // R9
   round_bubble_chk: assert property (@(posedge clk) disable iff (rst)
      !v_i |-> ##3 !v_o);
   // R5
   dir_carry_chk: assert property (@(posedge clk) disable iff (rst)
      v_i |-> ##3 (dec_o == $past(dec_i, 3)));
   // R6
   key_carry_chk: assert property (@(posedge clk) disable iff (rst)
      v_i |-> ##3 (key_o == $past(key_i, 3)));
   // R1
   half_swap_chk: assert property (@(posedge clk) disable iff (rst)
      v_i |-> ##3 (l_o == $past(r_i, 3)));
endmodule

// File: rtl/des_ecb_pipe.sv
module des_ecb_pipe
   import des_pkg::*;
#(
   parameter int ROUNDS = 16,
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_decrypt,
   input  logic [WORD_W-1:0] in_key,
   input  logic [WORD_W-1:0] in_block,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_block
);
   localparam int HW = WORD_W / 2;

   if (ROUNDS != ROUND_N) begin : g_bad_rounds
      $error("des_ecb_pipe: ROUNDS must equal 16");
   end
   if (WORD_W != BLK_W) begin : g_bad_width
      $error("des_ecb_pipe: WORD_W must equal 64");
   end

   logic              v_ch   [ROUNDS+1];
   logic              dec_ch [ROUNDS+1];
   logic [CD_W-1:0]   key_ch [ROUNDS+1];
   logic [HW-1:0]     l_ch   [ROUNDS+1];
   logic [HW-1:0]     r_ch   [ROUNDS+1];
   logic [WORD_W-1:0] permuted_in;

   assign permuted_in = ip_fwd(in_block);
   assign v_ch[0]     = in_valid;
   assign dec_ch[0]   = in_decrypt;
   assign key_ch[0]   = pc1(in_key);
   assign l_ch[0]     = permuted_in[WORD_W-1:HW];
   assign r_ch[0]     = permuted_in[HW-1:0];

   for (genvar g = 0; g < ROUNDS; g++) begin : g_rnd
      des_round #(.RND(g)) u_round (
         .clk  (clk),
         .rst  (rst),
         .v_i  (v_ch[g]),
         .dec_i(dec_ch[g]),
         .key_i(key_ch[g]),
         .l_i  (l_ch[g]),
         .r_i  (r_ch[g]),
         .v_o  (v_ch[g+1]),
         .dec_o(dec_ch[g+1]),
         .key_o(key_ch[g+1]),
         .l_o  (l_ch[g+1]),
         .r_o  (r_ch[g+1])
      );
   end

   assign out_valid = v_ch[ROUNDS];
   assign out_block = ip_inv({r_ch[ROUNDS], l_ch[ROUNDS]});
endmodule

// File: tb/des_ecb_pipe_bench.sv
module des_ecb_pipe_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_decrypt = 1'b0;
   logic [63:0] in_key = '0;
   logic [63:0] in_block = '0;
   logic        out_valid;
   logic [63:0] out_block;

   int n_chk = 0, n_err = 0, n_out = 0, n_sent = 0, cyc = 0;
   bit done = 1'b0;

   logic [63:0] exp_q[$];
   int          stamp_q[$];
   string       tag_q[$];

   des_ecb_pipe u_des_ecb_pipe (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_decrypt(in_decrypt),
      .in_key(in_key), .in_block(in_block),
      .out_valid(out_valid), .out_block(out_block)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   task automatic send(logic [63:0] k, logic [63:0] b, bit d, logic [63:0] e, string tag);
      @(negedge clk);
      in_valid = 1'b1; in_key = k; in_block = b; in_decrypt = d;
      exp_q.push_back(e); stamp_q.push_back(cyc); tag_q.push_back(tag);
      n_sent++;
   endtask

   // idle slots carry changing junk that must produce nothing
   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_block = ~in_block;
         in_key = in_key ^ 64'h5A5A_3C3C_0F0F_9669;
         in_decrypt = ~in_decrypt;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin : mon
      logic [63:0] e;
      int st;
      string tg;
      if (!rst && out_valid) begin
         n_out++;
         if (exp_q.size() == 0) check(1'b0, "R9", "unexpected result", out_block, 64'h0);
         else begin
            e = exp_q.pop_front(); st = stamp_q.pop_front(); tg = tag_q.pop_front();
            check(out_block == e, tg, "result", out_block, e);
            check(cyc - st == 48, "R3", "latency", 64'(cyc - st), 64'd48);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R3 watchdog expired actual=%0d expected=<20000", cyc);
      report();
   end

   initial begin : main
      int base;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R8", "out_valid during reset", 64'(out_valid), 64'h0);
      @(negedge clk); rst = 1'b0;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R8", "out_valid after reset", 64'(out_valid), 64'h0);

      // back-to-back stream, key and direction change every clock (R4 R5 R6)
      send(64'h0, 64'h8000000000000000, 0, 64'h95F8A5E5DD31D900, "R1");
      send(64'h0, 64'h95F8A5E5DD31D900, 1, 64'h8000000000000000, "R2");
      send(64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 0, 64'h85E813540F0AB405, "R6");
      send(64'h133457799BBCDFF1, 64'h85E813540F0AB405, 1, 64'h0123456789ABCDEF, "R5");
      send(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 0, 64'h7359B2163E4EDC58, "R1");
      send(64'h0E329232EA6D0D73, 64'h0000000000000000, 1, 64'h8787878787878787, "R2");
      send(64'h0E329232EA6D0D73, 64'h8787878787878787, 0, 64'h0000000000000000, "R5");
      send(64'h0, 64'h0, 0, 64'h8CA64DE9C1B123A7, "R1");
      send(64'h0, 64'h4000000000000000, 0, 64'hDD7F121CA5015619, "R4");
      send(64'h0101010101010101, 64'h8000000000000000, 0, 64'h95F8A5E5DD31D900, "R7");
      send(64'hFEFEFEFEFEFEFEFE, 64'h7359B2163E4EDC58, 1, 64'hFFFFFFFFFFFFFFFF, "R7");
      idle(60);
      check(exp_q.size() == 0, "R4", "results outstanding", 64'(exp_q.size()), 64'h0);
      check(n_out == n_sent, "R4", "result count", 64'(n_out), 64'(n_sent));

      // sparse traffic with junk in the gaps
      for (int i = 0; i < 6; i++) begin
         if (i % 2 == 0) send(64'h0, 64'h8CA64DE9C1B123A7, 1, 64'h0, "R9");
         else send(64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 0, 64'h85E813540F0AB405, "R9");
         idle(i % 3 + 1);
      end
      idle(60);
      check(n_out == n_sent, "R9", "result count with gaps", 64'(n_out), 64'(n_sent));

      // reset with blocks in flight
      send(64'h0, 64'h0, 0, 64'h8CA64DE9C1B123A7, "R8");
      send(64'h0, 64'h0, 0, 64'h8CA64DE9C1B123A7, "R8");
      send(64'h0, 64'h0, 0, 64'h8CA64DE9C1B123A7, "R8");
      @(negedge clk); in_valid = 1'b0; rst = 1'b1;
      repeat (2) @(negedge clk);
      exp_q.delete(); stamp_q.delete(); tag_q.delete();
      base = n_out;
      rst = 1'b0;
      idle(60);
      check(n_out == base, "R8", "flushed blocks emerged", 64'(n_out - base), 64'h0);

      send(64'h0, 64'h8000000000000000, 0, 64'h95F8A5E5DD31D900, "R8");
      idle(60);
      check(exp_q.size() == 0, "R8", "post-reset block missing", 64'(exp_q.size()), 64'h0);
      report();
   end
endmodule